// File: doc/BRIEF.md
# Max-Scaled ReLU Requantiser

This block sits behind the dot-product array of a neural-network layer. It takes one vector of N signed 32-bit neuron sums per cycle, clamps the negative lanes to zero and narrows every lane to an unsigned 8-bit code. All lanes of one vector share a single right-shift. That shift is chosen so that the largest lane of the vector keeps its leading one in bit 7 of its output code.

The vector passes through four parts in order. A bank of sign-selected multiplexers performs the ReLU. A comparator tree, registered at every level, finds the maximum. A detector turns the leading-one position of that maximum into a shift amount. A truncation stage then cuts the same 8-bit window out of every lane. While the tree works, a delay buffer holds the clamped vector. The block is fully pipelined and accepts a new vector in every cycle. It also reports the shift it used with each vector, so that later stages can track the scale of each layer.

Top module: `maxscale_requant`

## Requirements
- R1: A lane whose input has bit 31 set (negative in two's complement) gives output code 0, and it does not take part in the choice of the maximum.
- R2: `out_valid` equals `in_valid` delayed by exactly log2(N)+3 cycles. A vector is accepted in every cycle, and idle cycles pass through as idle cycles.
- R3: One shift is chosen per vector, from the largest lane after ReLU, and it applies to every lane of that vector.
- R4: Let p be the bit index of the leading one of that maximum. `out_shift` is p-7 when p is 7 or more. It is 0 when p is below 7 or when the maximum is zero.
- R5: Lane j of `out_data` (bits 8j+7..8j) equals bits s+7..s of the clamped lane j, where s is `out_shift`. That is, it is the clamped value divided by 2^s, modulo 256.
- R6: A vector whose lanes are all zero or all negative gives all-zero codes and a shift of 0.
- R7: When `out_shift` is non-zero, the output code of the lane that holds the maximum has bit 7 set.
- R8: Vectors that arrive back to back with different scales each use their own shift. No shift is carried over from a neighbouring vector.
- R9: While reset is held and after it is released, `out_valid`, `out_data` and `out_shift` are 0 until the first vector reaches the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector present this cycle |
| in_data | input | N*32 | Signed 32-bit sums, lane j at bits 32j+31..32j |
| out_valid | output | 1 | Output vector present this cycle |
| out_data | output | N*8 | Requantised codes, lane j at bits 8j+7..8j |
| out_shift | output | 5 | Right shift applied to this output vector |

## Verification
The case that is hardest to reach from the ports is a stream of vectors with unrelated scales moving through the pipeline together. In that case the shift of one vector must not meet the buffered data of another. The bench reaches it by sweeping the leading-one position from 0 to 30 in a pseudo-random order with no idle cycles, so that neighbouring vectors in the tree and the buffer differ in scale. Negative lanes, all-zero vectors, ties and the largest positive value are mixed in. Idle gaps are inserted elsewhere so that the valid path is checked against the data path.

// File: rtl/mrq_pkg.sv
package mrq_pkg;
  parameter int ACC_W = 32;
  parameter int Q_W   = 8;
  parameter int SH_W  = $clog2(ACC_W);

  // Sign-selected clamp.
  function automatic logic [ACC_W-1:0] relu(input logic [ACC_W-1:0] v);
    return v[ACC_W-1] ? '0 : v;
  endfunction

  function automatic logic [ACC_W-1:0] vmax(input logic [ACC_W-1:0] a,
                                            input logic [ACC_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  // Index of the highest set bit, -1 for zero.
  function automatic int lead_pos(input logic [ACC_W-1:0] v);
    int p;
    p = -1;
    for (int i = 0; i < ACC_W; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic logic [SH_W-1:0] shift_for(input int p);
    if (p >= Q_W - 1) return SH_W'(p - (Q_W - 1));
    return '0;
  endfunction

  function automatic logic [Q_W-1:0] requant(input logic [ACC_W-1:0] v,
                                             input logic [SH_W-1:0] sh);
    return Q_W'(v >> sh);
  endfunction
endpackage

// File: rtl/mrq_relu_bank.sv
module mrq_relu_bank
  import mrq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [N*ACC_W-1:0] in_data,
  output logic             vld_q,
  output logic [N*ACC_W-1:0] vec_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      vec_q <= '0;
    end else begin
      vld_q <= in_valid;
      for (int j = 0; j < N; j++)
        vec_q[j*ACC_W +: ACC_W] <= relu(in_data[j*ACC_W +: ACC_W]);
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_chk
    // R1: a negative lane is stored as zero
    a_r1_neg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_data[j*ACC_W+ACC_W-1]) |-> (vec_q[j*ACC_W +: ACC_W] == '0));
  end
endmodule

// File: rtl/mrq_max_tree.sv
module mrq_max_tree
  import mrq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N*ACC_W-1:0] leaves,
  output logic [ACC_W-1:0]   max_o
);
  localparam int LVL = $clog2(N);

  for (genvar lv = 0; lv <= LVL; lv++) begin : lv_g
    localparam int CNT = N >> lv;
    logic [ACC_W-1:0] mx [CNT];
    if (lv == 0) begin : g_leaf
      always_comb
        for (int j = 0; j < CNT; j++) mx[j] = leaves[j*ACC_W +: ACC_W];
    end else begin : g_node
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int j = 0; j < CNT; j++) mx[j] <= '0;
        end else begin
          for (int j = 0; j < CNT; j++)
            mx[j] <= vmax(lv_g[lv-1].mx[2*j], lv_g[lv-1].mx[2*j+1]);
        end
      end
    end
  end

  assign max_o = lv_g[LVL].mx[0];

  if (LVL > 0) begin : g_chk
    for (genvar j = 0; j < N; j++) begin : g_lane
      // R3: the root dominates every leaf it was built from
      a_r3_root_bound: assert property (@(posedge clk) disable iff (!rst_n)
        max_o >= $past(leaves[j*ACC_W +: ACC_W], LVL));
    end
  end
endmodule

// File: rtl/mrq_shift_sel.sv
module mrq_shift_sel
  import mrq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] max_i,
  output logic [SH_W-1:0]  shift_q
);
  logic [SH_W-1:0] shift_d;
  assign shift_d = shift_for(lead_pos(max_i));

  always_ff @(posedge clk) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  // R4: a non-zero shift leaves the leading one exactly at the top of the window
  a_r4_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_q != '0) |-> ((32'($past(max_i)) >> (int'(shift_q) + Q_W - 1)) == 32'd1));
  // R4: a zero shift means the maximum already fits in the code width
  a_r4_fits: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_q == '0) |-> (32'($past(max_i)) < (32'd1 << Q_W)));
endmodule

// File: rtl/mrq_delay.sv
module mrq_delay #(
  parameter int W = 8,
  parameter int D = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] tap [D+1];
  assign tap[0] = d_i;

  for (genvar k = 1; k <= D; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) tap[k] <= '0;
      else        tap[k] <= tap[k-1];
    end
  end

  assign d_o = tap[D];
endmodule

// File: rtl/maxscale_requant.sv
module maxscale_requant
  import mrq_pkg::*;
#(
  parameter int N = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [N*ACC_W-1:0] in_data,
  output logic               out_valid,
  output logic [N*Q_W-1:0]   out_data,
  output logic [SH_W-1:0]    out_shift
);
  localparam int LVL = $clog2(N);
  localparam int LAT = LVL + 3;
  localparam int BUF_D = LVL + 1;

  // Named internal events
  logic               relu_vld;
  logic [N*ACC_W-1:0] relu_vec;
  logic [ACC_W-1:0]   tree_max;
  logic [SH_W-1:0]    sel_shift;
  logic [N*ACC_W-1:0] buf_vec;
  logic               buf_vld;
  logic [N-1:0]       lane_msb;

  mrq_relu_bank #(.N(N)) relu_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .vld_q(relu_vld), .vec_q(relu_vec));

  mrq_max_tree #(.N(N)) tree_i (
    .clk(clk), .rst_n(rst_n), .leaves(relu_vec), .max_o(tree_max));

  mrq_shift_sel shsel_i (
    .clk(clk), .rst_n(rst_n), .max_i(tree_max), .shift_q(sel_shift));

  mrq_delay #(.W(N*ACC_W), .D(BUF_D)) vbuf_i (
    .clk(clk), .rst_n(rst_n), .d_i(relu_vec), .d_o(buf_vec));

  mrq_delay #(.W(1), .D(BUF_D)) vdly_i (
    .clk(clk), .rst_n(rst_n), .d_i(relu_vld), .d_o(buf_vld));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_shift <= '0;
    end else begin
      out_valid <= buf_vld;
      out_shift <= sel_shift;
      for (int j = 0; j < N; j++)
        out_data[j*Q_W +: Q_W] <= requant(buf_vec[j*ACC_W +: ACC_W], sel_shift);
    end
  end

  always_comb
    for (int j = 0; j < N; j++) lane_msb[j] = out_data[j*Q_W + Q_W - 1];

  // R2: fixed latency, one vector per cycle
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, LAT));
  // R7: a scaled vector uses the full code range in at least one lane
  a_r7_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_shift != '0) |-> (lane_msb != '0));
  // R5: the shift used at the output is the one chosen for the buffered vector
  a_r5_shift_align: assert property (@(posedge clk) disable iff (!rst_n)
    out_shift == $past(sel_shift));
endmodule

// File: tb/maxscale_requant_tb_top.sv
module maxscale_requant_tb_top;
  localparam int N = 8;
  localparam int LAT = $clog2(N) + 3;
  localparam int MAXV = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [N*32-1:0] in_data = '0;
  logic out_valid;
  logic [N*8-1:0] out_data;
  logic [4:0] out_shift;

  always #4 clk = ~clk;

  maxscale_requant #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_shift(out_shift));

  int n_chk = 0, n_fail = 0, k = 0;
  bit done = 1'b0;
  bit     hv   [MAXV];
  int     esh  [MAXV];
  int     eout [MAXV][N];
  int     emax [MAXV];
  bit     eneg [MAXV][N];
  bit     ezero[MAXV];
  bit     eb2b [MAXV];
  logic [31:0] seed = 32'h1234_5678;

  function automatic logic [31:0] lcg();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (vector %0d)", req, act, exp, k);
    end
  endtask

  // Expected values from the requirements, by arithmetic.
  task automatic expect_vec(input logic [N*32-1:0] v, input bit b2b);
    longint r [N];
    longint m;
    int p, s, mi;
    m = 0; mi = 0;
    for (int j = 0; j < N; j++) begin
      r[j] = longint'($signed(v[j*32 +: 32]));
      eneg[k][j] = (r[j] < 0);
      if (r[j] < 0) r[j] = 0;
      if (r[j] > m) begin m = r[j]; mi = j; end
    end
    p = -1;
    while ((64'sd1 <<< (p + 1)) <= m) p++;
    s = (p >= 7) ? p - 7 : 0;
    esh[k] = s; emax[k] = mi; ezero[k] = (m == 0); eb2b[k] = b2b;
    for (int j = 0; j < N; j++) eout[k][j] = int'((r[j] / (64'sd1 <<< s)) % 256);
  endtask

  task automatic check_out();
    int idx;
    if (k < LAT) begin
      check("R2 valid before first result", longint'(out_valid), 0);
      return;
    end
    idx = k - LAT;
    check("R2 valid timing", longint'(out_valid), longint'(hv[idx]));
    if (!hv[idx]) return;
    if (eb2b[idx]) check("R8 shift per vector", longint'(out_shift), esh[idx]);
    else           check("R4 R3 shift", longint'(out_shift), esh[idx]);
    for (int j = 0; j < N; j++) begin
      if (ezero[idx])     check("R6 zero vector", longint'(out_data[j*8 +: 8]), 0);
      else if (eneg[idx][j]) check("R1 negative lane", longint'(out_data[j*8 +: 8]), 0);
      else                check("R5 lane code", longint'(out_data[j*8 +: 8]), eout[idx][j]);
    end
    if (esh[idx] > 0)
      check("R7 max lane top bit", longint'(out_data[emax[idx]*8 + 7]), 1);
  endtask

  task automatic step(input bit v, input logic [N*32-1:0] vec, input bit b2b);
    @(negedge clk);
    check_out();
    in_valid = v;
    in_data  = vec;
    hv[k] = v;
    if (v) expect_vec(vec, b2b);
    k++;
  endtask

  // Vector whose maximum has its leading one at bit p; kind picks the lane mix.
  function automatic logic [N*32-1:0] build(input int p, input int kind);
    logic [N*32-1:0] v;
    logic [31:0] msk, top;
    msk = (p >= 31) ? 32'h7FFF_FFFF : ((32'd1 << p) - 32'd1);
    top = 32'd1 << p;
    for (int j = 0; j < N; j++) begin
      if (kind == 2) v[j*32 +: 32] = top;
      else if (kind == 1 && j % 2 == 1) v[j*32 +: 32] = -((lcg() & 32'hFFFF) + 32'd1);
      else v[j*32 +: 32] = lcg() & msk;
    end
    v[(p % N)*32 +: 32] = top | (lcg() & msk);
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset valid", longint'(out_valid), 0);
    check("R9 reset data", longint'(out_data), 0);
    check("R9 reset shift", longint'(out_shift), 0);
    rst_n = 1'b1;

    // Sweep every leading-one position, with gaps, three lane mixes each
    for (int p = 0; p < 31; p++) begin
      for (int kind = 0; kind < 3; kind++) step(1'b1, build(p, kind), 1'b0);
      if (p % 4 == 0) step(1'b0, '0, 1'b0);
    end
    // R6: all zero, all negative, one negative extreme
    step(1'b1, '0, 1'b0);
    step(1'b1, {N{32'h8000_0000}}, 1'b0);
    step(1'b1, {N{32'hFFFF_FFFF}}, 1'b0);
    // Largest positive value and a tie
    step(1'b1, {N{32'h7FFF_FFFF}}, 1'b0);
    step(1'b1, {{(N-1){32'd5}}, 32'h7FFF_FFFF}, 1'b0);
    // R8: back-to-back vectors with scattered scales
    for (int i = 0; i < 62; i++) step(1'b1, build((i * 17) % 31, i % 3), 1'b1);
    // Idle mixed with vectors
    for (int i = 0; i < 20; i++) step(i % 3 != 0, build((i * 7) % 31, 1), 1'b0);
    for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, 1'b0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule